// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter for a processor subsystem. Software programs a 24-bit reload value and sets the run bit. The counter then decrements once per core clock. When it has reached zero, it reloads on the next step, so it produces one tick every reload+1 clocks until software stops it. Each transition from 1 to 0 sets a sticky status flag. If the interrupt-enable bit is set, the same transition also sends a one-cycle pend request to the interrupt controller.

Software reaches the block through a simple port with valid, write, byte address and 32-bit data. The status/control word holds the run bit, the interrupt-enable bit, a clock-source bit that always reads 1, and the sticky flag. Reading that word returns the flag and then clears it. Any write to the count word zeroes the counter and clears the flag, and it never raises a pend.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word at 0x10 reads 0x00000004, the reload word at 0x14 and the count word at 0x18 read 0, and tickPend is low.
- R2: In the control word, bit 0 is the run bit and bit 1 is the interrupt enable, both writable and read back. Bit 2 always reads 1 and ignores writes. Bit 16 is the sticky flag and ignores writes. All other bits read 0.
- R3: The reload word stores bits 23:0 of a write; bits 31:24 read 0.
- R4: While the run bit is set, the count drops by one per clock; from 0 it loads the reload value, giving one 1-to-0 transition every reload+1 clocks.
- R5: Setting the run bit with a count of 0 loads the reload value on the first clock, without setting the flag.
- R6: A 1-to-0 transition sets the flag; a read of the control word returns it and clears it after that read.
- R7: A control-word read in the same cycle as a 1-to-0 transition returns the old flag and leaves the flag set.
- R8: A write of any value to 0x18 zeroes the count and clears the flag; it takes priority over counting and never causes a pend.
- R9: With the interrupt enable set, each 1-to-0 transition drives tickPend high for exactly the following cycle; with it clear, tickPend stays low.
- R10: A reload value of 0 keeps the running count at 0, with no flag and no pend.
- R11: Addresses other than 0x10, 0x14 and 0x18 read 0, and writes to them change nothing.
- R12: While the run bit is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the count clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word, same cycle |
| tickPend | output | 1 | One-cycle pend request to the interrupt controller |

## Verification
A wrong count shows on the next read of 0x18, and it also shifts the tickPend pulse train from one transition onward. So the bench reads the count back to back, cycle by cycle, across a reload and counts pend pulses over fixed windows. A flag stuck high or low appears on the very next control-word read, so the bench issues reads in the cycle before, during and after a transition. A pend raised by a count-word write, or by a zero reload, would appear one cycle later on tickPend; the windows around those writes must show no pulse.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Control word field positions (software decodes these)
  localparam int RUN_BIT  = 0;
  localparam int IRQ_BIT  = 1;
  localparam int SRC_BIT  = 2;
  localparam int FLAG_BIT = 16;

  // Strobes from the control side to the counter
  typedef struct packed {
    logic clear;  // software write to the count word
    logic step;   // run bit set: advance one count
  } cntCmd_t;

endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             zeroEvt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Decrement that lands on zero; a clear in the same cycle suppresses it
  always_comb zeroEvt = cmd.step && !cmd.clear && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (cmd.clear) count <= '0;
    else if (cmd.step)  count <= (count == '0) ? reloadVal : count - ONE;
  end

  // R8: a clear strobe zeroes the count
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (count == '0));

  // R4: a step from a nonzero value decrements by one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.clear && count != '0) |=> (count == $past(count) - ONE));

  // R10: with a zero reload, a running zero count stays zero
  a_r10_zero_reload: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.clear && count == '0 && reloadVal == '0) |=> (count == '0));

  // R12: no strobe, no change
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.step && !cmd.clear) |=> $stable(count));

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter int              CNT_W    = 24,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h10,
  parameter logic [ADDR_W-1:0] OFS_RLD  = 'h14,
  parameter logic [ADDR_W-1:0] OFS_VAL  = 'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              zeroEvt,
  output cntCmd_t           cmd,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              tickPend
);

  logic runEn, irqEn, cntFlag;
  logic wrCtrl, wrRld, wrVal, rdCtrl;
  logic unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:CNT_W];

  always_comb begin
    wrCtrl = busValid &&  busWrite && (busAddr == OFS_CTRL);
    wrRld  = busValid &&  busWrite && (busAddr == OFS_RLD);
    wrVal  = busValid &&  busWrite && (busAddr == OFS_VAL);
    rdCtrl = busValid && !busWrite && (busAddr == OFS_CTRL);
  end

  always_comb begin
    cmd.clear = wrVal;
    cmd.step  = runEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      irqEn     <= 1'b0;
      reloadVal <= '0;
    end else begin
      if (wrCtrl) begin
        runEn <= busWdata[RUN_BIT];
        irqEn <= busWdata[IRQ_BIT];
      end
      if (wrRld) reloadVal <= busWdata[CNT_W-1:0];
    end
  end

  // Sticky flag: a set event wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                 cntFlag <= 1'b0;
    else if (zeroEvt)          cntFlag <= 1'b1;
    else if (rdCtrl || wrVal)  cntFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tickPend <= 1'b0;
    else       tickPend <= zeroEvt && irqEn;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_CTRL: begin
        busRdata[RUN_BIT]  = runEn;
        busRdata[IRQ_BIT]  = irqEn;
        busRdata[SRC_BIT]  = 1'b1;
        busRdata[FLAG_BIT] = cntFlag;
      end
      OFS_RLD: busRdata[CNT_W-1:0] = reloadVal;
      OFS_VAL: busRdata[CNT_W-1:0] = count;
      default: ;
    endcase
  end

  // R6: a zero transition leaves the flag set afterwards
  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |=> cntFlag);

  // R8: a count-word write clears the flag
  a_r8_write_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    wrVal |=> !cntFlag);

  // R9: a pend always accompanies a set flag
  a_r9_pend_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    tickPend |-> cntFlag);

  // R9: masked interrupts never pend
  a_r9_masked_no_pend: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |=> !tickPend);

  // R9: the pend is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tickPend |=> !tickPend);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 24,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h10,
  parameter logic [ADDR_W-1:0] OFS_RLD  = 'h14,
  parameter logic [ADDR_W-1:0] OFS_VAL  = 'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickPend
);

  cntCmd_t          cmd;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] count;
  logic             zeroEvt;

  tick_timer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .OFS_CTRL(OFS_CTRL), .OFS_RLD(OFS_RLD), .OFS_VAL(OFS_VAL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .zeroEvt(zeroEvt),
    .cmd(cmd), .reloadVal(reloadVal), .tickPend(tickPend)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reloadVal(reloadVal),
    .count(count), .zeroEvt(zeroEvt)
  );

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_RLD  = 8'h14;
  localparam logic [7:0] A_VAL  = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickPend;

  int compared = 0;
  int mismatched = 0;
  int pendHigh = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] expVal;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickPend(tickPend)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: count pend cycles, compare each read against the scoreboard
  always @(negedge clk) begin
    if (tickPend === 1'b1) pendHigh++;
    if (rstN && busValid && !busWrite) begin
      if (expQ.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, busRdata, it.expVal);
      end
    end
  end

  // Each operation occupies exactly one cycle; entry is just after an edge
  task automatic opWrite(input logic [7:0] addr, input logic [31:0] data);
    busValid = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic opRead(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    expQ.push_back('{expVal: exp, tag: tag});
    busValid = 1'b1; busWrite = 1'b0; busAddr = addr;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    pendHigh = 0;

    // R1 reset state
    opRead(A_CTRL, 32'h4, "R1 ctrl after reset");
    opRead(A_RLD,  32'h0, "R1 reload after reset");
    opRead(A_VAL,  32'h0, "R1 count after reset");
    check("R1 no pend after reset", 32'(pendHigh), 32'd0);

    // R2 fixed source bit, non-writable flag
    opWrite(A_CTRL, 32'h0000_0000);
    opRead(A_CTRL, 32'h4, "R2 source bit ignores write of 0");
    opWrite(A_CTRL, 32'h0001_0000);
    opRead(A_CTRL, 32'h4, "R2 flag not writable");
    opWrite(A_CTRL, 32'hFFFE_FFFA);
    opRead(A_CTRL, 32'h6, "R2 only irq bit and source bit");
    opWrite(A_CTRL, 32'h0);

    // R3 reload width
    opWrite(A_RLD, 32'hFFFF_FFFF);
    opRead(A_RLD, 32'h00FF_FFFF, "R3 reload masked to 24 bits");

    // R11 unmapped addresses
    opWrite(8'h1C, 32'h1234_5678);
    opRead(8'h1C, 32'h0, "R11 unmapped reads zero");
    opRead(8'h00, 32'h0, "R11 address 0 reads zero");
    opRead(A_RLD, 32'h00FF_FFFF, "R11 unmapped write left reload");

    // R4/R5/R6/R7: reload 5, interrupt masked
    opWrite(A_RLD, 32'd5);
    opWrite(A_VAL, 32'd0);
    pendHigh = 0;
    opWrite(A_CTRL, 32'h1);
    opRead(A_VAL, 32'd0, "R5 count zero before first step");
    opRead(A_VAL, 32'd5, "R5 first step loads reload");
    opRead(A_VAL, 32'd4, "R4 decrement");
    opRead(A_VAL, 32'd3, "R4 decrement");
    opRead(A_VAL, 32'd2, "R4 decrement");
    opRead(A_CTRL, 32'h5, "R7 read in transition cycle sees old flag");
    opRead(A_CTRL, 32'h0001_0005, "R7 flag kept after coincident read");
    opRead(A_CTRL, 32'h5, "R6 flag cleared by read");
    check("R9 masked interrupt no pend", 32'(pendHigh), 32'd0);

    // R9/R4 period with interrupt enabled, reload 3
    opWrite(A_CTRL, 32'h0);
    opWrite(A_RLD, 32'd3);
    opWrite(A_VAL, 32'd0);
    opWrite(A_CTRL, 32'h3);
    pendHigh = 0;
    idle(21);
    check("R9 five pulses in 21 cycles at period 4", 32'(pendHigh), 32'd5);
    opRead(A_CTRL, 32'h0001_0007, "R6 flag set by transition");

    // R12 hold while stopped
    opWrite(A_CTRL, 32'h2);
    opRead(A_VAL, 32'd1, "R12 count held");
    opRead(A_VAL, 32'd1, "R12 count still held");

    // R8 write clears flag
    opWrite(A_CTRL, 32'h3);
    pendHigh = 0;
    idle(1);
    opWrite(A_VAL, 32'h00AB_CDEF);
    opRead(A_VAL, 32'd0, "R8 write zeroes count");
    opRead(A_CTRL, 32'h7, "R8 write cleared flag");
    check("R9 single pulse for one transition", 32'(pendHigh), 32'd1);

    // R8 write overriding a 1-to-0 step: no pend, no flag
    pendHigh = 0;
    idle(1);
    opWrite(A_VAL, 32'd0);
    idle(2);
    check("R8 write at count 1 gives no pend", 32'(pendHigh), 32'd0);
    opRead(A_CTRL, 32'h7, "R8 write at count 1 sets no flag");

    // R10 zero reload
    opWrite(A_CTRL, 32'h0);
    opWrite(A_RLD, 32'd0);
    opWrite(A_VAL, 32'd0);
    opWrite(A_CTRL, 32'h3);
    pendHigh = 0;
    idle(10);
    opRead(A_VAL, 32'd0, "R10 count stays zero");
    opRead(A_CTRL, 32'h7, "R10 no flag");
    check("R10 no pend", 32'(pendHigh), 32'd0);

    idle(2);
    check("scoreboard drained", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule